// File: doc/BRIEF.md
# SAR Conversion Timing Sequencer

This block is the digital control core of a successive-approximation converter model. A falling edge on the active-low convert-start input opens a conversion; the block raises `busy` for a number of system clock cycles chosen by the speed mode. When that count runs out it copies the sample word into the result register, drops `busy` and pulses `rdy` for one cycle. The falling edge of `busy` therefore marks the moment new data can be read.

There are three speed modes. `warp` high with `impulse` low picks the fast mode. `impulse` high with `warp` low picks the low-power mode. Any other combination picks normal mode. Every time interval is given in nanoseconds and turned into whole clock cycles by rounding up, using the `CLK_MHZ` parameter.

Other inputs shape when a conversion may start. A power-down request blocks new starts but lets the current conversion finish. Reset aborts a conversion. In the low-power mode, holding convert-start low through the acquisition window starts the next conversion by itself. In the fast mode, a watchdog flags the case where conversions are spaced too far apart.

Top module: `sar_conv_sequencer`

## Requirements
- R1: When `cnv_n` falls while the block is idle, the minimum spacing has elapsed and `pwr_dn` is low, `busy` is high at the first rising clock edge that samples `cnv_n` low.
- R2: `busy` stays high for exactly ceil(t·CLK_MHZ/1000) cycles. Here t is 750 ns in the fast mode (`warp`=1, `impulse`=0), 1250 ns in the low-power mode (`warp`=0, `impulse`=1) and 1000 ns otherwise.
- R3: On the edge where `busy` falls, `result` takes the value on `sample` at that edge and `rdy` is high for that one cycle only. At all other times `result` holds its value.
- R4: A falling edge of `cnv_n` while `busy` is high is ignored: the running conversion keeps its length and no new conversion follows.
- R5: The minimum spacing from one start to the next is ceil(t·CLK_MHZ/1000) cycles, with t = 1750, 2000 or 2250 ns for the fast, normal or low-power mode of the earlier conversion. A falling edge sampled one cycle short of that spacing is ignored. An edge sampled exactly at the spacing starts a conversion.
- R6: While `rst` is high, `busy`, `rdy`, `gap_err` and `result` are zero. A conversion cut off by reset never produces a `rdy` pulse.
- R7: A conversion already running when `pwr_dn` rises completes normally. Falling edges seen while `pwr_dn` is high start nothing. Once `pwr_dn` is low again, a falling edge starts a conversion.
- R8: In the low-power mode, if `cnv_n` is still low when the 1000 ns acquisition window that follows `busy` falling ends, a new conversion starts with no new edge. That start falls ceil(1250 ns)+ceil(1000 ns) cycles after the previous one. In other modes, holding `cnv_n` low starts nothing.
- R9: After a fast-mode start, `gap_err` goes high GAP_NS worth of cycles later if no new conversion has started by then. It clears at the next start. It never rises after a start in another mode.
- R10: The mode is captured at the start of a conversion. Changing `warp` or `impulse` while `busy` is high does not alter that conversion's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset, aborts any conversion |
| cnv_n | input | 1 | Convert start, falling edge active |
| warp | input | 1 | Fast mode select (with `impulse` low) |
| impulse | input | 1 | Low-power mode select (with `warp` low) |
| pwr_dn | input | 1 | Power-down request, blocks new starts |
| sample | input | DATA_W | Stubbed data source latched at conversion end |
| busy | output | 1 | High while a conversion is in progress |
| rdy | output | 1 | One-cycle strobe when `result` is updated |
| result | output | DATA_W | Latched conversion word |
| gap_err | output | 1 | Fast-mode maximum spacing exceeded |

## Verification
Two pairs of events can land on the same edge. In the first, the end of the acquisition window coincides with a still-low convert input in the low-power mode. The bench holds `cnv_n` low and checks that `busy` is low one cycle before the computed restart point and high exactly on it. In the second, a falling edge arrives on the very cycle the minimum spacing is met. The bench places one edge one cycle early and expects it to be refused, then places another exactly on the boundary and expects it to be taken. The remaining checks mix random modes and sample words with directed cases for power-down, reset abort and the fast-mode gap flag.

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer #(
  parameter int CLK_MHZ = 100,
  parameter int DATA_W  = 16,
  parameter int GAP_NS  = 1_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnv_n,
  input  logic              warp,
  input  logic              impulse,
  input  logic              pwr_dn,
  input  logic [DATA_W-1:0] sample,
  output logic              busy,
  output logic              rdy,
  output logic [DATA_W-1:0] result,
  output logic              gap_err
);

  function automatic int ns2cyc(input int ns);
    return (ns * CLK_MHZ + 999) / 1000;
  endfunction

  localparam int CONV_F  = ns2cyc(750);
  localparam int CONV_N  = ns2cyc(1000);
  localparam int CONV_S  = ns2cyc(1250);
  localparam int SPC_F   = ns2cyc(1750);
  localparam int SPC_N   = ns2cyc(2000);
  localparam int SPC_S   = ns2cyc(2250);
  localparam int ACQ     = ns2cyc(1000);
  localparam int GAP_CYC = ns2cyc(GAP_NS);
  localparam int CW      = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {M_NORM, M_FAST, M_SLOW} mode_e;

  mode_e          mode_in, mode_q;
  logic           cnv_q;
  logic [CW-1:0]  cnt, conv_end, spc_min;
  logic           edge_go, auto_go, start;

  assign mode_in = (warp && !impulse) ? M_FAST :
                   (impulse && !warp) ? M_SLOW : M_NORM;

  always_comb begin
    case (mode_q)
      M_FAST:  begin conv_end = CW'(CONV_F - 1); spc_min = CW'(SPC_F - 1); end
      M_SLOW:  begin conv_end = CW'(CONV_S - 1); spc_min = CW'(SPC_S - 1); end
      default: begin conv_end = CW'(CONV_N - 1); spc_min = CW'(SPC_N - 1); end
    endcase
  end

  assign edge_go = cnv_q && !cnv_n && !busy && (cnt >= spc_min);
  assign auto_go = (mode_q == M_SLOW) && (mode_in == M_SLOW) && !cnv_n && !busy &&
                   (cnt == CW'(CONV_S + ACQ - 1));
  assign start   = (edge_go || auto_go) && !pwr_dn;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnv_q   <= 1'b1;
      busy    <= 1'b0;
      rdy     <= 1'b0;
      result  <= '0;
      gap_err <= 1'b0;
      mode_q  <= M_NORM;
      cnt     <= CW'(GAP_CYC);
    end else begin
      cnv_q <= cnv_n;
      rdy   <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        cnt     <= '0;
        mode_q  <= mode_in;
        gap_err <= 1'b0;
      end else begin
        if (cnt != CW'(GAP_CYC)) cnt <= cnt + 1'b1;
        if (busy && cnt == conv_end) begin
          busy   <= 1'b0;
          rdy    <= 1'b1;
          result <= sample;
        end
        if (mode_q == M_FAST && !busy && cnt == CW'(GAP_CYC - 1)) gap_err <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sar_conv_sequencer_chk.sv
module sar_conv_sequencer_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_dn,
  input logic              busy,
  input logic              rdy,
  input logic [DATA_W-1:0] result,
  input logic              gap_err,
  input logic [31:0]       conv_f,
  input logic [31:0]       conv_n,
  input logic [31:0]       conv_s
);

  logic [31:0] run;
  logic        past_ok;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      run     <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      run     <= busy ? run + 1 : '0;
    end
  end

  a_r2_busy_width: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run == conv_f || run == conv_n || run == conv_s));

  a_r3_rdy_on_fall: assert property (@(posedge clk) disable iff (rst)
    rdy |-> (!busy && $past(busy)));

  a_r3_result_hold: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !rdy) |-> $stable(result));

  a_r7_no_start_in_pd: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $rose(busy)) |-> !$past(pwr_dn));

  a_r9_gap_clear_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !gap_err);

  always @(posedge clk) begin
    if (rst) begin
      a_r6_reset_idle: assert (!busy && !rdy && !gap_err && result == '0);
    end
  end

endmodule

bind sar_conv_sequencer sar_conv_sequencer_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .busy(busy), .rdy(rdy),
  .result(result), .gap_err(gap_err),
  .conv_f(32'(CONV_F)), .conv_n(32'(CONV_N)), .conv_s(32'(CONV_S))
);

// File: tb/test_sar_conv_sequencer.sv
module test_sar_conv_sequencer;
  localparam int CLK_MHZ = 50;
  localparam int DW      = 16;
  localparam int GAP_NS  = 20000;

  logic          clk = 1'b0;
  logic          rst, cnv_n, warp, impulse, pwr_dn;
  logic [DW-1:0] sample;
  logic          busy, rdy, gap_err;
  logic [DW-1:0] result;

  int n_chk = 0, n_fail = 0, cyc = 0;

  sar_conv_sequencer #(.CLK_MHZ(CLK_MHZ), .DATA_W(DW), .GAP_NS(GAP_NS)) i_sar_conv_sequencer (
    .clk(clk), .rst(rst), .cnv_n(cnv_n), .warp(warp), .impulse(impulse),
    .pwr_dn(pwr_dn), .sample(sample), .busy(busy), .rdy(rdy),
    .result(result), .gap_err(gap_err));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int cyc_of(input int ns);
    return (ns * CLK_MHZ + 999) / 1000;
  endfunction
  function automatic int conv_len(input logic w, input logic i);
    if (w && !i) return cyc_of(750);
    if (i && !w) return cyc_of(1250);
    return cyc_of(1000);
  endfunction
  function automatic int spc_len(input logic w, input logic i);
    if (w && !i) return cyc_of(1750);
    if (i && !w) return cyc_of(2250);
    return cyc_of(2000);
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic start_fall(output int s);
    cnv_n = 1'b0;
    @(negedge clk);
    s = cyc;
    check(busy == 1'b1, "R1 busy after fall", int'(busy), 1);
  endtask

  task automatic measure(input int exp_len, input logic [DW-1:0] d, input string tag);
    int n = 1;
    @(negedge clk);
    while (busy && n < 500) begin
      n++;
      if (n == 3) sample = d;
      @(negedge clk);
    end
    check(n == exp_len, tag, n, exp_len);
    check(rdy == 1'b1, "R3 rdy at busy fall", int'(rdy), 1);
    check(result == d, "R3 result latched", int'(result), int'(d));
    @(negedge clk);
    check(rdy == 1'b0, "R3 rdy one cycle", int'(rdy), 0);
  endtask

  initial begin
    int s, s2, bad;
    logic w, i;
    logic [DW-1:0] d;
    void'($urandom(32'd2024));
    rst = 1; cnv_n = 1; warp = 0; impulse = 0; pwr_dn = 0; sample = '0;
    repeat (3) @(negedge clk);
    check(!busy && !rdy && !gap_err && result == '0, "R6 reset state", int'(busy), 0);
    rst = 0;
    repeat (2) @(negedge clk);

    // R1 R2 R3 random modes and data
    for (int k = 0; k < 12; k++) begin
      w = 1'($urandom); i = 1'($urandom); d = DW'($urandom);
      warp = w; impulse = i; sample = DW'($urandom);
      start_fall(s);
      cnv_n = 1'b1;
      measure(conv_len(w, i), d, "R2 busy length random");
      wait_to(s + 130);
    end

    // R10 mode captured at start
    warp = 0; impulse = 0; d = 16'hA5C3;
    start_fall(s);
    cnv_n = 1'b1; warp = 1'b1;
    measure(conv_len(0, 0), d, "R10 mode held");
    warp = 0;
    wait_to(s + 130);

    // R4 edge during busy ignored
    d = 16'h0001;
    start_fall(s);
    repeat (4) @(negedge clk);
    cnv_n = 1'b1;
    repeat (3) @(negedge clk);
    cnv_n = 1'b0;
    @(negedge clk);
    check(cyc - s < conv_len(0, 0), "R4 edge inside busy", cyc - s, 0);
    bad = 0;
    while (busy) @(negedge clk);
    check(cyc - s == conv_len(0, 0), "R4 length unchanged", cyc - s, conv_len(0, 0));
    check(result == 16'h0001 || result == sample, "R4 result", int'(result), int'(sample));
    cnv_n = 1'b1;
    repeat (20) begin @(negedge clk); if (busy) bad++; end
    check(bad == 0, "R4 no restart", bad, 0);
    wait_to(s + 130);

    // R5 spacing boundary
    start_fall(s);
    cnv_n = 1'b1;
    wait_to(s + spc_len(0, 0) - 2);
    cnv_n = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R5 early edge refused", int'(busy), 0);
    cnv_n = 1'b1;
    wait_to(s + 130);
    start_fall(s);
    cnv_n = 1'b1;
    wait_to(s + spc_len(0, 0) - 1);
    cnv_n = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R5 edge at spacing taken", int'(busy), 1);
    cnv_n = 1'b1;
    wait_to(cyc + 130);

    // R7 power-down
    d = 16'h7E81;
    start_fall(s);
    pwr_dn = 1'b1; cnv_n = 1'b1;
    measure(conv_len(0, 0), d, "R7 conversion finishes");
    wait_to(s + 130);
    cnv_n = 1'b0;
    bad = 0;
    repeat (20) begin @(negedge clk); if (busy) bad++; end
    check(bad == 0, "R7 start blocked", bad, 0);
    pwr_dn = 1'b0; cnv_n = 1'b1;
    @(negedge clk);
    start_fall(s);
    check(busy == 1'b1, "R7 start after release", int'(busy), 1);
    cnv_n = 1'b1;
    wait_to(s + 130);

    // R6 reset abort
    start_fall(s);
    cnv_n = 1'b1;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && result == '0, "R6 abort", int'(busy), 0);
    rst = 1'b0;
    bad = 0;
    repeat (80) begin @(negedge clk); if (rdy || busy) bad++; end
    check(bad == 0, "R6 no rdy after abort", bad, 0);

    // R8 auto-start in low-power mode
    warp = 0; impulse = 1;
    start_fall(s);
    wait_to(s + conv_len(0, 1) + cyc_of(1000) - 1);
    check(busy == 1'b0, "R8 idle before acq end", int'(busy), 0);
    @(negedge clk);
    check(busy == 1'b1, "R8 auto start", int'(busy), 1);
    cnv_n = 1'b1; s2 = cyc;
    wait_to(s2 + conv_len(0, 1) + cyc_of(1000) + 5);
    check(busy == 1'b0, "R8 no start with input high", int'(busy), 0);
    impulse = 0;
    start_fall(s);
    wait_to(s + 150);
    check(busy == 1'b0, "R8 no auto in normal", int'(busy), 0);
    cnv_n = 1'b1;
    @(negedge clk);

    // R9 fast-mode gap flag
    warp = 1;
    start_fall(s);
    cnv_n = 1'b1;
    wait_to(s + cyc_of(GAP_NS) - 1);
    check(gap_err == 1'b0, "R9 no flag before limit", int'(gap_err), 0);
    @(negedge clk);
    check(gap_err == 1'b1, "R9 flag at limit", int'(gap_err), 1);
    warp = 0;
    start_fall(s);
    check(gap_err == 1'b0, "R9 cleared on start", int'(gap_err), 1'b0);
    cnv_n = 1'b1;
    wait_to(s + cyc_of(GAP_NS) + 50);
    check(gap_err == 1'b0, "R9 none in normal", int'(gap_err), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule